// File: doc/BRIEF.md
# Programmable PCM Frame Serialiser

This block drives the transmit side of a two-channel serial audio link. It runs on the bit clock. It either produces the frame-sync signal itself or follows a frame sync that comes from outside. Within each frame it shifts two channel samples out MSB first, each starting at a bit offset and with a width that are both programmed. A single offset-and-width mechanism therefore covers I2S, left- and right-justified, DSP pulse-sync and TDM slot layouts. The frame is up to 1024 bit clocks long.

Samples arrive as a pair through a valid/ready handshake into a one-entry holding stage. At every frame start the held pair is committed to the frame and a one-cycle request pulse marks bit 0. If nothing is held at that moment, the frame carries zeros and a sticky underrun flag rises.

A small state machine classifies the bit being driven. The states are:
- HUNT: slave sync mode, no sync edge seen yet.
- GAP: a bit outside both channel windows.
- CH1: a bit inside the channel 1 window.
- CH2: a bit inside the channel 2 window.

The transitions are:
- HUNT→GAP/CH1/CH2 on the first sync edge.
- GAP→CH1 or GAP→CH2 when a window opens.
- CH1→CH2 when the windows are adjacent.
- CH1/CH2→GAP when a window closes.
- Any state→CH1/CH2/GAP at a frame start.
- The reset state is HUNT in slave mode. It is left in the first cycle in master mode.

Top module: `pcm_frame_serialiser`

## Requirements
- R1: In master mode (`cfg_fs_slave`=0), frames repeat every `cfg_frame_len_m1`+1 bit clocks, starting in the first cycle after reset. `fs_out` is active for bit positions below `cfg_sync_len` and inactive otherwise. `fs_out` changes together with the data bit of that position.
- R2: With `cfg_fs_inv`=1, the active level of frame sync is low for both `fs_out` and `fs_in`. A frame therefore begins on a falling sync edge.
- R3: `cfg_slots[31:16]` configures channel 1 and `cfg_slots[15:0]` configures channel 2. Each half-word has the same layout:
  - bit 15: width extend.
  - bit 14: enable.
  - bits 13:4: start position.
  - bits 3:0: width code.
  
  The width is code+8, plus 16 when extend is set. An enabled channel sends its sample MSB first, from the start position for that many bits. Channel 1 wins where the windows overlap.
- R4: Bits outside both windows are 0, and so is every bit of a disabled channel.
- R5: `s_ready` is high when the holding stage is empty, or when the current bit is a frame start. A pair accepted while held data is being committed at a frame start replaces it in the holding stage.
- R6: At a frame start with nothing held and at least one channel enabled, that frame's channel bits are 0 and `underrun` rises. `underrun` stays high until reset.
- R7: `frame_req` is high for exactly the bit clock that carries frame position 0.
- R8: In slave mode (`cfg_fs_slave`=1), a frame starts at the bit clock whose rising edge first samples the sync at its active level after it was inactive. Data therefore follows a sync change by one bit. `sdata` is 0 until the first such edge. `fs_out` is 0 and `fs_oe` is low in slave mode; `fs_oe` is high in master mode.
- R9: With `cfg_clk_inv`=0, `sdata` changes after the rising bit-clock edge. With `cfg_clk_inv`=1, the same bit stream is delayed by half a bit and changes on the falling edge.
- R10: `bclk_oe` is the inverse of `cfg_bclk_slave`.
- R11: For widths above the sample width of 32 bits, the window starts with leading zeros, followed by all 32 sample bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_len_m1 | input | 10 | Frame length minus one (master) |
| cfg_sync_len | input | 10 | Bit clocks of active sync per frame |
| cfg_fs_slave | input | 1 | 1: follow external frame sync |
| cfg_bclk_slave | input | 1 | 1: bit clock comes from outside |
| cfg_fs_inv | input | 1 | 1: sync active low, frame starts on falling edge |
| cfg_clk_inv | input | 1 | 1: launch data on falling bit-clock edge |
| cfg_slots | input | 32 | Channel window configuration, two half-words |
| fs_in | input | 1 | External frame sync |
| s_valid | input | 1 | Sample pair valid |
| s_ch1 | input | 32 | Channel 1 sample |
| s_ch2 | input | 32 | Channel 2 sample |
| s_ready | output | 1 | Sample pair accepted when high with valid |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Drive enable for frame sync pad |
| bclk_oe | output | 1 | Drive enable for bit-clock pad |
| sdata | output | 1 | Serial data |
| frame_req | output | 1 | Frame-start pulse / sample request |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Two events can fall in the same cycle:
- the frame start that commits the held pair into the frame, and
- the acceptance of a new pair into the holding stage.

Holding `s_valid` high continuously provokes this collision at every frame, because the stage is then always full when a frame begins. The behavioural model predicts `s_ready` from its own queue and frame counter. It compares both that prediction and the next frame's bit stream every cycle, so a lost or duplicated sample would show up as a data mismatch. Phases with sparse valid also let frame starts meet an empty stage, which judges the underrun path.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

    // one half-word of the channel window configuration
    typedef struct packed {
        logic       wext;
        logic       en;
        logic [9:0] start;
        logic [3:0] wcode;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_GAP,
        ST_CH1,
        ST_CH2
    } ser_state_e;

    function automatic logic [5:0] slot_width(slot_cfg_t c);
        return 6'd8 + {2'b00, c.wcode} + (c.wext ? 6'd16 : 6'd0);
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fs_slave,
    input  logic               fs_inv,
    input  logic [FRAME_W-1:0] frame_len_m1,
    input  logic [FRAME_W-1:0] sync_len,
    input  logic               fs_in,
    output logic [FRAME_W-1:0] pos,
    output logic               fstart,
    output logic               locked_nxt,
    output logic               fs_out
);
    logic [FRAME_W-1:0] cnt_q;
    logic               run_q, act_q, locked_q, fs_q;
    logic               act, sync_edge;

    always_comb begin
        act        = fs_in ^ fs_inv;
        sync_edge  = act & ~act_q;
        fstart     = fs_slave ? sync_edge : (!run_q || (cnt_q == frame_len_m1));
        pos        = fstart ? '0 : cnt_q + 1'b1;
        locked_nxt = !fs_slave || locked_q || sync_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            run_q    <= 1'b0;
            act_q    <= 1'b0;
            locked_q <= 1'b0;
            fs_q     <= 1'b0;
        end else begin
            cnt_q    <= pos;
            run_q    <= 1'b1;
            act_q    <= act;
            locked_q <= locked_nxt;
            fs_q     <= fs_slave ? 1'b0 : ((pos < sync_len) ^ fs_inv);
        end
    end

    assign fs_out = fs_q;
endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window
    import pcm_ser_pkg::*;
#(
    parameter int FRAME_W  = 10,
    parameter int SAMPLE_W = 32
) (
    input  slot_cfg_t           cfg,
    input  logic [FRAME_W-1:0]  pos,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                hit,
    output logic                bit_o
);
    localparam int EXT_W = FRAME_W + 2;
    localparam int SEL_W = $clog2(SAMPLE_W);

    logic [EXT_W-1:0] pos_x, start_x, wid_x, off, idx;

    always_comb begin
        pos_x   = EXT_W'(pos);
        start_x = EXT_W'(cfg.start);
        wid_x   = EXT_W'(slot_width(cfg));
        off     = pos_x - start_x;
        idx     = wid_x - off - EXT_W'(1);
        hit     = cfg.en && (pos_x >= start_x) && (off < wid_x);
        bit_o   = (idx < EXT_W'(SAMPLE_W)) ? sample[idx[SEL_W-1:0]] : 1'b0;
    end
endmodule

// File: rtl/pcm_sample_stage.sv
module pcm_sample_stage #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fstart,
    input  logic                any_en,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_ch1,
    input  logic [SAMPLE_W-1:0] s_ch2,
    output logic                s_ready,
    output logic [SAMPLE_W-1:0] src1,
    output logic [SAMPLE_W-1:0] src2,
    output logic                underrun
);
    logic                full_q, under_q, take;
    logic [SAMPLE_W-1:0] hold1_q, hold2_q, frm1_q, frm2_q;

    always_comb begin
        s_ready = !full_q || fstart;
        take    = s_valid && s_ready;
        src1    = fstart ? (full_q ? hold1_q : '0) : frm1_q;
        src2    = fstart ? (full_q ? hold2_q : '0) : frm2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            under_q <= 1'b0;
            hold1_q <= '0;
            hold2_q <= '0;
            frm1_q  <= '0;
            frm2_q  <= '0;
        end else begin
            if (fstart) begin
                frm1_q <= full_q ? hold1_q : '0;
                frm2_q <= full_q ? hold2_q : '0;
            end
            under_q <= under_q | (fstart & ~full_q & any_en);
            full_q  <= (full_q & ~fstart) | take;
            if (take) begin
                hold1_q <= s_ch1;
                hold2_q <= s_ch2;
            end
        end
    end

    assign underrun = under_q;
endmodule

// File: rtl/pcm_frame_serialiser.sv
module pcm_frame_serialiser
    import pcm_ser_pkg::*;
#(
    parameter int FRAME_W  = 10,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FRAME_W-1:0]  cfg_frame_len_m1,
    input  logic [FRAME_W-1:0]  cfg_sync_len,
    input  logic                cfg_fs_slave,
    input  logic                cfg_bclk_slave,
    input  logic                cfg_fs_inv,
    input  logic                cfg_clk_inv,
    input  logic [31:0]         cfg_slots,
    input  logic                fs_in,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_ch1,
    input  logic [SAMPLE_W-1:0] s_ch2,
    output logic                s_ready,
    output logic                fs_out,
    output logic                fs_oe,
    output logic                bclk_oe,
    output logic                sdata,
    output logic                frame_req,
    output logic                underrun
);
    localparam int N_CH = 2;

    logic [FRAME_W-1:0]  pos;
    logic                fstart, locked_nxt, any_en;
    logic [SAMPLE_W-1:0] src [N_CH];
    logic [N_CH-1:0]     hit, win_bit;
    slot_cfg_t           slot_cfg [N_CH];
    ser_state_e          state_q, state_d;
    logic                bit_d, bit_q, sd_p, sd_n_q, req_q;

    pcm_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .fs_slave(cfg_fs_slave), .fs_inv(cfg_fs_inv),
        .frame_len_m1(cfg_frame_len_m1), .sync_len(cfg_sync_len),
        .fs_in(fs_in), .pos(pos), .fstart(fstart),
        .locked_nxt(locked_nxt), .fs_out(fs_out)
    );

    pcm_sample_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .fstart(fstart), .any_en(any_en),
        .s_valid(s_valid), .s_ch1(s_ch1), .s_ch2(s_ch2),
        .s_ready(s_ready), .src1(src[0]), .src2(src[1]),
        .underrun(underrun)
    );

    // channel 1 in the upper half-word, channel 2 in the lower
    for (genvar k = 0; k < N_CH; k++) begin : g_slot
        assign slot_cfg[k] = cfg_slots[(N_CH-1-k)*16 +: 16];
        pcm_slot_window #(.FRAME_W(FRAME_W), .SAMPLE_W(SAMPLE_W)) u_win (
            .cfg(slot_cfg[k]), .pos(pos), .sample(src[k]),
            .hit(hit[k]), .bit_o(win_bit[k])
        );
    end

    assign any_en = slot_cfg[0].en | slot_cfg[1].en;

    // next-state classification of the bit about to be driven
    always_comb begin
        if (!locked_nxt)  state_d = ST_HUNT;
        else if (hit[0])  state_d = ST_CH1;
        else if (hit[1])  state_d = ST_CH2;
        else              state_d = ST_GAP;
    end

    always_comb begin
        unique case (state_d)
            ST_HUNT: bit_d = 1'b0;
            ST_GAP:  bit_d = 1'b0;
            ST_CH1:  bit_d = win_bit[0];
            ST_CH2:  bit_d = win_bit[1];
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            req_q   <= fstart;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_HUNT, ST_GAP: sd_p = 1'b0;
            ST_CH1, ST_CH2:  sd_p = bit_q;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sd_n_q <= 1'b0;
        else        sd_n_q <= sd_p;
    end

    assign sdata     = cfg_clk_inv ? sd_n_q : sd_p;
    assign frame_req = req_q;
    assign fs_oe     = !cfg_fs_slave;
    assign bclk_oe   = !cfg_bclk_slave;
endmodule

// File: rtl/pcm_frame_serialiser_chk.sv
module pcm_frame_serialiser_chk
    import pcm_ser_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fs_slave,
    input logic               fs_inv,
    input logic               clk_inv,
    input logic [FRAME_W-1:0] frame_len_m1,
    input logic [FRAME_W-1:0] sync_len,
    input logic               frame_req,
    input logic               fs_out,
    input logic               s_valid,
    input logic               s_ready,
    input logic               full,
    input logic               underrun,
    input ser_state_e         state,
    input logic               sdata
);
    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !fs_slave && frame_len_m1 != '0) |=> !frame_req);

    // R1
    sync_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !fs_slave && sync_len != '0) |-> (fs_out == !fs_inv));

    // R5
    accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> full);

    // R6
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R4
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_inv && state == ST_GAP) |-> !sdata);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_slave |=> !fs_out);
endmodule

bind pcm_frame_serialiser pcm_frame_serialiser_chk #(.FRAME_W(FRAME_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .fs_slave(cfg_fs_slave), .fs_inv(cfg_fs_inv),
    .clk_inv(cfg_clk_inv), .frame_len_m1(cfg_frame_len_m1),
    .sync_len(cfg_sync_len), .frame_req(frame_req), .fs_out(fs_out),
    .s_valid(s_valid), .s_ready(s_ready), .full(u_stage.full_q),
    .underrun(underrun), .state(state_q), .sdata(sdata)
);

// File: tb/test_pcm_frame_serialiser.sv
module test_pcm_frame_serialiser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_frame_len_m1 = '0, cfg_sync_len = '0;
    logic        cfg_fs_slave = 0, cfg_bclk_slave = 0, cfg_fs_inv = 0, cfg_clk_inv = 0;
    logic [31:0] cfg_slots = '0;
    logic        fs_in = 0, s_valid = 0;
    logic [31:0] s_ch1 = '0, s_ch2 = '0;
    logic        s_ready, fs_out, fs_oe, bclk_oe, sdata, frame_req, underrun;

    always #10 clk = ~clk;  // 50 MHz

    pcm_frame_serialiser i_pcm_frame_serialiser (.*);

    int n_cmp = 0, n_bad = 0;

    // behavioural reference state
    int          m_cnt;
    bit          m_run, m_actq, m_locked, m_full, m_under, m_cur, m_prev, e_req, e_fs;
    logic [31:0] m_h1, m_h2, m_f1, m_f2;

    function automatic int wid(logic [15:0] c);
        return 8 + int'(c[3:0]) + (c[15] ? 16 : 0);
    endfunction

    function automatic bit in_win(logic [15:0] c, int pos);
        int st = int'(c[13:4]);
        return c[14] && pos >= st && (pos - st) < wid(c);
    endfunction

    function automatic bit win_bit(logic [15:0] c, int pos, logic [31:0] d);
        int idx = wid(c) - 1 - (pos - int'(c[13:4]));
        return (idx < 32) ? d[idx] : 1'b0;
    endfunction

    function automatic bit pred_fstart();
        bit act = fs_in ^ cfg_fs_inv;
        return cfg_fs_slave ? (act && !m_actq) : (!m_run || m_cnt == int'(cfg_frame_len_m1));
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_run = 0; m_actq = 0; m_locked = 0; m_full = 0; m_under = 0;
        m_cur = 0; m_prev = 0; e_req = 0; e_fs = 0;
        m_h1 = '0; m_h2 = '0; m_f1 = '0; m_f2 = '0;
    endtask

    task automatic model_step();
        bit act, edge_s, fst, rdy, take;
        int pos;
        logic [15:0] c1, c2;
        c1 = cfg_slots[31:16];
        c2 = cfg_slots[15:0];
        act    = fs_in ^ cfg_fs_inv;
        edge_s = act && !m_actq;
        m_actq = act;
        fst    = cfg_fs_slave ? edge_s : (!m_run || m_cnt == int'(cfg_frame_len_m1));
        rdy    = !m_full || fst;
        take   = s_valid && rdy;
        pos    = fst ? 0 : (m_cnt + 1) % 1024;
        m_cnt  = pos;
        m_run  = 1;
        m_locked = !cfg_fs_slave || m_locked || edge_s;
        if (fst) begin
            if (m_full) begin m_f1 = m_h1; m_f2 = m_h2; end
            else begin
                m_f1 = '0; m_f2 = '0;
                if (c1[14] || c2[14]) m_under = 1;
            end
        end
        m_full = (m_full && !fst) || take;
        if (take) begin m_h1 = s_ch1; m_h2 = s_ch2; end
        m_prev = m_cur;
        if (!m_locked)            m_cur = 0;
        else if (in_win(c1, pos)) m_cur = win_bit(c1, pos, m_f1);
        else if (in_win(c2, pos)) m_cur = win_bit(c2, pos, m_f2);
        else                      m_cur = 0;
        e_req = fst;
        e_fs  = cfg_fs_slave ? 1'b0 : ((pos < int'(cfg_sync_len)) ^ cfg_fs_inv);
    endtask

    // one bit clock: inputs already driven at the preceding falling edge
    task automatic tick();
        #2;
        if (rst_n) check("R5 s_ready", s_ready, !m_full || pred_fstart());
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        #5;
        check("R7 frame_req", frame_req, e_req);
        check("R1 R2 R8 fs_out", fs_out, e_fs);
        check("R3 R4 R9 R11 sdata", sdata, cfg_clk_inv ? m_prev : m_cur);
        check("R6 underrun", underrun, m_under);
        check("R8 fs_oe", fs_oe, !cfg_fs_slave);
        check("R10 bclk_oe", bclk_oe, !cfg_bclk_slave);
        @(negedge clk);
    endtask

    task automatic start(input logic [9:0] flm1, input logic [9:0] slen,
                         input bit fslave, input bit bslave, input bit finv,
                         input bit cinv, input logic [31:0] slots);
        rst_n = 0;
        s_valid = 0;
        fs_in = 0;
        cfg_frame_len_m1 = flm1; cfg_sync_len = slen;
        cfg_fs_slave = fslave; cfg_bclk_slave = bslave;
        cfg_fs_inv = finv; cfg_clk_inv = cinv; cfg_slots = slots;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1;
    endtask

    task automatic run(int cycles, int vprob, bit ext_fs, int period, int high, bit finv);
        for (int i = 0; i < cycles; i++) begin
            s_valid = ($urandom_range(99) < vprob);
            s_ch1 = $urandom;
            s_ch2 = $urandom;
            if (ext_fs) fs_in = (i < 10) ? finv : (((i % period) < high) ^ finv);
            tick();
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        // I2S-like: 64-bit frame, 50% sync, inverted, 16-bit data one bit late
        start(10'd63, 10'd32, 0, 0, 1, 0, {1'b0, 1'b1, 10'd1, 4'd8, 1'b0, 1'b1, 10'd33, 4'd8});
        run(200, 100, 0, 1, 1, 0);   // collision of commit and accept each frame
        run(150, 0, 0, 1, 1, 0);     // starve: R6 underrun
        // DSP pulse sync, data at position 0, 24 + 8 bits, falling-edge launch
        start(10'd31, 10'd1, 0, 1, 0, 1, {1'b1, 1'b1, 10'd0, 4'd0, 1'b0, 1'b1, 10'd24, 4'd0});
        run(400, 40, 0, 1, 1, 0);
        // slave sync, channel 2 disabled
        start(10'd0, 10'd0, 1, 1, 0, 0, {1'b0, 1'b1, 10'd2, 4'd12, 1'b0, 1'b0, 10'd26, 4'd12});
        run(500, 70, 1, 48, 24, 0);
        // slave sync inverted, data at position 0
        start(10'd0, 10'd0, 1, 0, 1, 0, {1'b0, 1'b1, 10'd0, 4'd8, 1'b0, 1'b1, 10'd20, 4'd8});
        run(400, 80, 1, 40, 20, 1);
        // long frame, channel 2 before channel 1, 39-bit padded window
        start(10'd127, 10'd64, 0, 0, 0, 0, {1'b1, 1'b1, 10'd96, 4'd8, 1'b1, 1'b1, 10'd8, 4'd15});
        run(600, 90, 0, 1, 1, 0);
        // one-bit frame: every bit is a frame start
        start(10'd0, 10'd1, 0, 0, 0, 0, {1'b0, 1'b1, 10'd0, 4'd0, 16'h0000});
        run(60, 60, 0, 1, 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule